// File: doc/BRIEF.md
# Broadcast-Accumulate Streaming FIR Filter

This block is a 64-tap finite impulse response filter built in transposed form, laid out the way a wide vector machine would compute it. Every accepted input sample is copied to all taps at once, each tap multiplies it by its own coefficient, and each product is added into that tap's running partial sum. The lowest partial sum, after the addition, becomes the output for that sample. The partial-sum vector then moves down one place, and a zero enters at the top.

The coefficients are written one tap at a time through a separate write port. Samples enter and results leave on two valid/ready streams. The block accepts one sample per cycle while the consumer keeps up. When the output is stalled, it holds the result and its internal state until the consumer takes the result.

Top module: `fir_bcast_stream`

## Requirements
- R1: A synchronous active-high reset clears every partial sum and every coefficient to zero, drops `res_valid`, and leaves `smp_ready` high once reset is released.
- R2: A coefficient write with `cw_en` high stores the signed 8-bit `cw_val` at tap `cw_tap` (0 to 63). Samples accepted after that write use the new value for that tap.
- R3: A coefficient write leaves the partial sums unchanged. Samples already accumulated keep the products they were given.
- R4: For every accepted sample x[n], the result equals the sum over k of c_k·x[n−k], where each c_k is the tap-k coefficient in force when x[n−k] was accepted.
- R5: The result of a sample accepted on a clock edge is presented on `res_data` with `res_valid` high right after that edge. While `res_ready` stays high, one sample is accepted on every cycle.
- R6: While `res_valid` is high and `res_ready` is low, `smp_ready` is low, and `res_data` and the partial sums hold their values.
- R7: In a cycle where `cw_en` is high, `smp_ready` is low, so no sample is accepted in that cycle. A pending sample is accepted in a later cycle.
- R8: The result is the full 22-bit signed partial sum. 64 full-scale products of −128·−128 give +1048576 without overflow.
- R9: A sample has no effect on results produced more than 63 accepted samples after it, because a zero enters at the top of the vector on every shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_tap | input | 6 | Tap index of the coefficient write |
| cw_val | input | 8 | Signed coefficient value |
| smp_valid | input | 1 | Input sample valid |
| smp_data | input | 8 | Signed input sample |
| smp_ready | output | 1 | Filter can take a sample this cycle |
| res_valid | output | 1 | Output result valid |
| res_data | output | 22 | Signed filter result |
| res_ready | input | 1 | Consumer takes the result |

## Verification
Two things can be requested in the same cycle: a coefficient write and the acceptance of a sample. Some stress phases fork a running sample stream alongside a single coefficient write, so that the write's strobe arrives while a sample is waiting to be accepted. The bench checks that ready is low in that cycle. It also checks that every later result matches a reference in which the write took effect before the delayed sample was accepted. A second kind of overlap comes from stalling the output while samples are still being offered. Here the held result, the low ready and the unchanged results that follow show that the stall does not disturb the state.

// File: rtl/fir_bcast_pkg.sv
package fir_bcast_pkg;
  // Width of an accumulator that cannot overflow for taps products of the given widths
  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS = 64,
  parameter int CW   = 8,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [CW-1:0] wr_val,
  output logic signed [CW-1:0] coef_o [TAPS]
);
  logic signed [CW-1:0] coef_q [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
    end else if (wr_en) begin
      coef_q[wr_idx] <= wr_val;
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) coef_o[k] = coef_q[k];
  end

  // R2
  coef_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> coef_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/fir_tap_lane.sv
module fir_tap_lane #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int AW = 22
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] c_i,
  input  logic signed [AW-1:0] psum_i,
  output logic signed [AW-1:0] sum_o
);
  logic signed [DW+CW-1:0] prod;
  logic signed [AW-1:0]    prod_ext;

  always_comb begin
    prod     = x_i * c_i;
    prod_ext = AW'(prod);
    sum_o    = psum_i + prod_ext;
  end
endmodule

// File: rtl/fir_bcast_stream.sv
module fir_bcast_stream #(
  parameter int TAPS = 64,
  parameter int DW   = 8,
  parameter int CW   = 8,
  localparam int IW  = $clog2(TAPS),
  localparam int AW  = fir_bcast_pkg::acc_width(DW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cw_en,
  input  logic [IW-1:0]        cw_tap,
  input  logic signed [CW-1:0] cw_val,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  output logic                 smp_ready,
  output logic                 res_valid,
  output logic signed [AW-1:0] res_data,
  input  logic                 res_ready
);
  logic signed [CW-1:0] coef [TAPS];
  logic signed [AW-1:0] psum_q [TAPS];
  logic signed [AW-1:0] acc [TAPS];
  logic                 take;
  logic                 res_valid_q;
  logic signed [AW-1:0] res_data_q;

  fir_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk(clk), .rst(rst), .wr_en(cw_en), .wr_idx(cw_tap),
    .wr_val(cw_val), .coef_o(coef)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_lane
    fir_tap_lane #(.DW(DW), .CW(CW), .AW(AW)) u_lane (
      .x_i(smp_data), .c_i(coef[k]), .psum_i(psum_q[k]), .sum_o(acc[k])
    );
  end

  assign smp_ready = !cw_en && (!res_valid_q || res_ready);
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) psum_q[k] <= '0;
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
    end else if (take) begin
      for (int k = 0; k < TAPS - 1; k++) psum_q[k] <= acc[k+1];
      psum_q[TAPS-1] <= '0;
      res_data_q     <= acc[0];
      res_valid_q    <= 1'b1;
    end else if (res_ready) begin
      res_valid_q <= 1'b0;
    end
  end

  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;

  // R5
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> res_valid);

  // R6
  stall_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R6
  stall_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> $stable(psum_q[0]));

  // R7
  write_blocks_sample_chk: assert property (@(posedge clk) disable iff (rst)
    cw_en |=> ($stable(res_data) && $stable(psum_q[0])));
endmodule

// File: tb/fir_bcast_stream_test.sv
`timescale 1ns/1ps
module fir_bcast_stream_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cw_en = 1'b0;
  logic [5:0] cw_tap = '0;
  logic signed [7:0] cw_val = '0;
  logic smp_valid = 1'b0;
  logic signed [7:0] smp_data = '0;
  logic smp_ready;
  logic res_valid;
  logic signed [21:0] res_data;
  logic res_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int bp_mode = 0;
  int mcoef [64];
  int mpsum [64];
  int exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  fir_bcast_stream uut (
    .clk(clk), .rst(rst), .cw_en(cw_en), .cw_tap(cw_tap), .cw_val(cw_val),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // consumer back-pressure
  always @(negedge clk) begin
    case (bp_mode)
      0: res_ready = 1'b1;
      1: res_ready = (cyc % 3) != 0;
      default: res_ready = $urandom_range(0, 3) == 0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && res_valid && !res_ready)
      check(smp_ready == 1'b0, "R6", int'(smp_ready), 0);
    if (!rst && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", int'(res_data), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(res_data) == e, t, int'(res_data), e);
      end
    end
  end

  task automatic model_reset();
    for (int k = 0; k < 64; k++) begin
      mcoef[k] = 0;
      mpsum[k] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 1'b0;
    #1;
    check(res_valid == 1'b0, "R1", int'(res_valid), 0);
    check(smp_ready == 1'b1, "R1", int'(smp_ready), 1);
  endtask

  task automatic send(input int x, input string tag);
    int acc [64];
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = 8'(x);
    #1;
    while (!smp_ready) begin
      @(negedge clk);
      #1;
    end
    for (int k = 0; k < 64; k++) acc[k] = mpsum[k] + mcoef[k] * x;
    for (int k = 0; k < 63; k++) mpsum[k] = acc[k+1];
    mpsum[63] = 0;
    exp_q.push_back(acc[0]);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
  endtask

  task automatic wr_coef(input int idx, input int val, input bit probe);
    @(negedge clk);
    cw_en = 1'b1;
    cw_tap = 6'(idx);
    cw_val = 8'(val);
    #1;
    if (probe) check(smp_ready == 1'b0, "R7", int'(smp_ready), 0);
    @(posedge clk);
    #1;
    cw_en = 1'b0;
    mcoef[idx] = val;
  endtask

  task automatic drain();
    bp_mode = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    model_reset();
    do_reset();

    // R1 / R4 / R9: impulse response of a signed ramp
    for (int k = 0; k < 64; k++) wr_coef(k, k - 32, 1'b0);
    send(1, "R1");
    for (int i = 1; i < 64; i++) send(0, "R4");
    for (int i = 0; i < 8; i++) send(0, "R9");
    drain();

    // R5: back-to-back acceptance, one sample per cycle
    begin
      time t0;
      t0 = $time;
      for (int i = 0; i < 20; i++) send(i - 10, "R5");
      check(($time - t0) <= 20 * 5 + 5, "R5", int'(($time - t0) / 5), 20);
    end
    drain();

    // R6 / R4: random stream under two stall patterns
    bp_mode = 1;
    for (int i = 0; i < 60; i++) send($urandom_range(0, 255) - 128, "R6");
    bp_mode = 2;
    for (int i = 0; i < 60; i++) send($urandom_range(0, 255) - 128, "R4");
    drain();

    // R3: coefficient writes between samples keep the accumulated sums
    for (int i = 0; i < 10; i++) send(i * 7 - 30, "R3");
    for (int k = 0; k < 64; k += 3) wr_coef(k, 50 - k, 1'b0);
    for (int i = 0; i < 20; i++) send(13 - i, "R3");
    drain();

    // R7: coefficient write collides with a waiting sample
    bp_mode = 1;
    fork
      for (int i = 0; i < 12; i++) send(i * 11 - 60, "R7");
      begin
        repeat (4) @(negedge clk);
        wr_coef(9, -77, 1'b1);
        repeat (3) @(negedge clk);
        wr_coef(0, 99, 1'b1);
      end
    join
    drain();

    // R2: a single tap written after reset
    do_reset();
    wr_coef(5, -7, 1'b0);
    send(3, "R2");
    for (int i = 0; i < 7; i++) send(0, "R2");
    drain();

    // R8: full-scale accumulation
    for (int k = 0; k < 64; k++) wr_coef(k, -128, 1'b0);
    for (int i = 0; i < 64; i++) send(-128, "R8");
    send(127, "R8");
    for (int i = 0; i < 70; i++) send(127, "R8");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule